// File: doc/BRIEF.md
# Sixteen-Bit External-Feedback Pseudo-Random Bit Source

This block is a 16-bit shift register with external XOR feedback. It produces a repeating pseudo-random bit stream that is 65535 bits long. On each rising clock edge every bit moves one place toward the right-hand end. The XOR of four fixed tap positions enters at the left-hand end. Both the whole register and its rightmost bit appear at the ports. The rightmost bit is the serial stream.

Reset is synchronous and active low. A low reset sampled at a rising edge loads the fixed starting value 16'hACE1. The block needs no other control, so it suits noise generation, test patterns or data whitening, with a known restart point.

Top module: `prbs16_fib`

## Requirements
- R1: When rst_n is low at a rising clock edge, the register holds 16'hACE1 after that edge. Holding rst_n low over several edges keeps it at 16'hACE1.
- R2: Register positions are numbered 1 (leftmost, port bit 15) to 16 (rightmost, port bit 0). When rst_n is high at an edge, each position takes the old value of its left neighbour. Position 1 takes the XOR of the old positions 16, 14, 13 and 11, which are port bits 0, 2, 3 and 5.
- R3: The first advance after reset takes the register from 16'hACE1 to 16'h5670. The next six values are AB38, 559C, 2ACE, 1567, 8AB3 and 4559.
- R4: serial_out always equals the rightmost register, port bit 0 of lfsr_state.
- R5: After reset, lfsr_state never reads zero.
- R6: Starting from the reset value, the register returns to 16'hACE1 for the first time after exactly 65535 advances.
- R7: When reset is low at an edge where an advance would otherwise take place, reset wins and the register holds 16'hACE1 after that edge, not the advanced value.
- R8: At the first edge after rst_n returns high, the register advances from 16'hACE1 to 16'h5670.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock; one advance per edge |
| rst_n | input | 1 | Synchronous active-low reset; loads 16'hACE1 |
| lfsr_state | output | 16 | Whole register; bit 15 is position 1, bit 0 is position 16 |
| serial_out | output | 1 | Rightmost register, the pseudo-random stream |

## Verification
Reload and advance can fall on the same edge. The register is always about to shift, so an edge with reset low also carries a pending advance. The bench drops reset in the middle of a run, after the register has left the starting value. It expects 16'hACE1 at the next edge, not the shifted value, and 16'h5670 at the first edge after release. A long run then counts advances until the starting value returns, and checks that zero never appears.

// File: rtl/prbs16_pkg.sv
// Package: shared widths, seed and tap set for the 16-bit pseudo-random source.
// Assumes positions are counted 1..WIDTH from the left (port bit WIDTH-1).
package prbs16_pkg;
    localparam int PRBS_W = 16;
    localparam int N_TAPS = 4;
    localparam logic [PRBS_W-1:0] PRBS_SEED = 16'hACE1;
    localparam int TAP_POS [N_TAPS] = '{16, 14, 13, 11};

    typedef logic [PRBS_W-1:0] prbs_word_t;

    // Turn left-counted tap positions into a bit mask over port bit indices.
    function automatic prbs_word_t build_tap_mask();
        prbs_word_t m;
        m = '0;
        for (int i = 0; i < N_TAPS; i++) begin
            m[PRBS_W - TAP_POS[i]] = 1'b1;
        end
        return m;
    endfunction

    localparam prbs_word_t TAP_MASK = build_tap_mask();
endpackage

// File: rtl/prbs16_feedback.sv
// Module: feedback network. Returns the XOR of the tapped register bits.
// Assumes the tap mask comes from the package; purely combinational.
module prbs16_feedback
    import prbs16_pkg::*;
#(
    parameter int W = PRBS_W,
    parameter logic [W-1:0] MASK = TAP_MASK
) (
    input  logic [W-1:0] cur_state,
    output logic         fb_bit
);
    localparam int NBITS = W;

    logic [NBITS:0] chain;

    assign chain[0] = 1'b0;

    // One XOR stage per register bit, each gated by the mask.
    for (genvar i = 0; i < NBITS; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ (cur_state[i] & MASK[i]);
    end

    assign fb_bit = chain[NBITS];
endmodule

// File: rtl/prbs16_shifter.sv
// Module: shift register of W flops moving toward bit 0. Bit W-1 takes
// the feedback bit. Synchronous active-low reset loads SEED.
module prbs16_shifter
    import prbs16_pkg::*;
#(
    parameter int W = PRBS_W,
    parameter logic [W-1:0] SEED = PRBS_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fb_in,
    output logic [W-1:0] q
);
    logic [W-1:0] d;

    // Next value of each flop: the left neighbour, or feedback at the left end.
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W-1) begin : g_head
            assign d[i] = fb_in;
        end else begin : g_body
            assign d[i] = q[i+1];
        end
    end

    // Register update: reload on reset, otherwise shift one place.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= d;
    end

    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q[W-2:0] == $past(q[W-1:1]))) else $error("shift");   // R2
endmodule

// File: rtl/prbs16_fib.sv
// Module: top of the 16-bit external-feedback pseudo-random bit source.
// Joins the feedback network to the shifter and brings out the stream.
// Assumes one advance per rising edge and a synchronous active-low reset.
module prbs16_fib
    import prbs16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [PRBS_W-1:0] lfsr_state,
    output logic              serial_out
);
    logic       fb;
    prbs_word_t st;

    prbs16_feedback #(.W(PRBS_W), .MASK(TAP_MASK)) u_fb (
        .cur_state (st),
        .fb_bit    (fb)
    );

    prbs16_shifter #(.W(PRBS_W), .SEED(PRBS_SEED)) u_sr (
        .clk   (clk),
        .rst_n (rst_n),
        .fb_in (fb),
        .q     (st)
    );

    assign lfsr_state = st;
    assign serial_out = st[0];

    AST_SEED_LOAD: assert property (@(posedge clk)
        !rst_n |=> (st == PRBS_SEED)) else $error("seed");                       // R1
    AST_FEEDBACK_IN: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (st[PRBS_W-1] == $past(st[0] ^ st[2] ^ st[3] ^ st[5]))) else $error("fb"); // R2
    AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PRBS_SEED) |=> (st == 16'h5670)) else $error("first");            // R3
    AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (st != '0)) else $error("zero");                        // R5
endmodule

// File: tb/tb_prbs16_fib.sv
module tb_prbs16_fib;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lfsr_state;
    logic        serial_out;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{16'hACE1, 16'h5670, 16'hAB38, 16'h559C,
                                         16'h2ACE, 16'h1567, 16'h8AB3, 16'h4559};

    always #2 clk = ~clk;

    prbs16_fib dut (.clk(clk), .rst_n(rst_n), .lfsr_state(lfsr_state), .serial_out(serial_out));

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #700000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int steps;
        bit saw_zero;
        repeat (3) @(negedge clk);
        chk("R1", lfsr_state, 16'hACE1);                  // held in reset
        rst_n = 1'b1;
        // R3 R4: walk the vector table, one advance per entry
        for (int i = 0; i < NV; i++) begin
            chk("R3", lfsr_state, VEC[i]);
            chk("R4", {15'd0, serial_out}, {15'd0, VEC[i][0]});
            @(negedge clk);
        end
        // R7: drop reset mid-run, advance pending
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", lfsr_state, 16'hACE1);
        @(negedge clk);
        chk("R1", lfsr_state, 16'hACE1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", lfsr_state, 16'h5670);
        // R2: one bench-model step from the present state
        begin
            logic [15:0] prev;
            prev = lfsr_state;
            @(negedge clk);
            chk("R2", lfsr_state, {prev[0] ^ prev[2] ^ prev[3] ^ prev[5], prev[15:1]});
        end
        // R6 R5: full period from reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        steps = 0;
        saw_zero = 1'b0;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk);
            steps++;
            if (lfsr_state == 16'h0000) saw_zero = 1'b1;
            if (lfsr_state == 16'hACE1) break;
        end
        chk("R6", steps[15:0], 16'hFFFF);
        chk("R6", {15'd0, steps > 65535}, 16'd0);
        chk("R5", {15'd0, saw_zero}, 16'd0);
        @(negedge clk);
        chk("R6", lfsr_state, 16'h5670);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule